// File: doc/BRIEF.md
# Ordered Store Buffer with Total and Partial Store Ordering

This block sits between one processor core and the memory write path. The core sends it one request per cycle: a store, a load, a barrier or an atomic operation. Stores are held in an eight-entry buffer and written to a banked memory write port, one per cycle. Loads are answered at once from the youngest buffered store to the same address when there is one. When there is no such store the load is reported as a miss, and the core reads memory itself.

A mode input sets the draining order. With total store order, only the oldest buffered store may be written, so memory sees stores in issue order. With partial store order, a younger store may be written ahead of an older store whose bank is busy. It may not pass an older store to the same address. Barriers and atomic operations are accepted only when the buffer is empty. Because of that rule, no store issued after a barrier can reach memory before a store issued ahead of the barrier.

Top module: `store_order_buffer`

## Requirements
- R1: After reset the buffer holds nothing. No write is presented, a load misses, and a barrier or atomic request is accepted in the same cycle.
- R2: Request codes on `core_op` are 2'b00 store, 2'b01 load, 2'b10 barrier and 2'b11 atomic. A store is accepted (`core_ready` high) while fewer than 8 entries are held. With 8 entries held it is refused, even in a cycle where a write drains.
- R3: A load is accepted in the same cycle it is presented, whatever the buffer holds.
- R4: A load whose address equals the address of one or more buffered stores gives `ld_hit`=1. In the same cycle `ld_data` carries the data of the youngest of those stores.
- R5: A load whose address matches no buffered store gives `ld_hit`=0.
- R6: A barrier or atomic request is accepted only in a cycle in which the buffer holds no entry.
- R7: The bank of an address is its bits [1:0]. A write is presented only when `mem_bank_rdy` is high for the bank of that write, and at most one write is made per cycle. `mem_wr_valid` high means the write is taken in that cycle.
- R8: With `pso_mode`=0 only the oldest buffered store may be written. If its bank is busy, nothing is written, and stores reach memory in issue order.
- R9: With `pso_mode`=1 the block writes the oldest buffered store that meets two conditions: its bank is ready, and no older buffered store has the same address. A younger store can therefore pass an older store whose bank is busy.
- R10: With `pso_mode`=1, stores to the same address still reach memory in issue order.
- R11: A store accepted in one cycle can be forwarded to a load in the next cycle. A store can be accepted in the same cycle that another entry is written.
- R12: Once a store has been written to memory it is no longer forwarded. A later load to that address misses unless a younger store to that address is still buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pso_mode | input | 1 | 0 selects total store order, 1 selects partial store order |
| core_valid | input | 1 | Core request present |
| core_op | input | 2 | Request code: store, load, barrier, atomic |
| core_addr | input | 16 | Request address |
| core_data | input | 32 | Store data |
| core_ready | output | 1 | Request accepted this cycle |
| ld_hit | output | 1 | Load matched a buffered store |
| ld_data | output | 32 | Forwarded load data |
| mem_bank_rdy | input | 4 | Per-bank write readiness |
| mem_wr_valid | output | 1 | Write taken this cycle |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 32 | Write data |

## Verification
A corrupted entry or a wrong age order inside the buffer shows up at the ports in one of two ways. A load to that address returns the wrong data in the same cycle. Or, in the first cycle that entry becomes eligible, the memory write carries the wrong address, data or order. A wrong occupancy count shows up as soon as a ninth store or a barrier is offered: `core_ready` is high or low when it should not be. Random traffic over a small address pool with random bank readiness in both modes exposes these faults within a few cycles. Directed sequences cover passing a busy bank, same-address ordering and the full buffer.

// File: rtl/sob_pkg.sv
package sob_pkg;

    localparam int SOB_AW        = 16;
    localparam int SOB_DW        = 32;
    localparam int SOB_DEPTH     = 8;
    localparam int SOB_BANK_BITS = 2;
    localparam int SOB_BANKS     = 1 << SOB_BANK_BITS;

    typedef enum logic [1:0] {
        OP_STORE  = 2'b00,
        OP_LOAD   = 2'b01,
        OP_FENCE  = 2'b10,
        OP_ATOMIC = 2'b11
    } core_op_e;

    typedef struct packed {
        logic              vld;
        logic [SOB_AW-1:0] addr;
        logic [SOB_DW-1:0] data;
    } sb_entry_t;

    function automatic logic [SOB_BANK_BITS-1:0] bank_of(input logic [SOB_AW-1:0] a);
        return a[SOB_BANK_BITS-1:0];
    endfunction

endpackage

// File: rtl/sob_queue.sv
module sob_queue
    import sob_pkg::*;
#(
    parameter int DEPTH = SOB_DEPTH,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [SOB_AW-1:0] push_addr,
    input  logic [SOB_DW-1:0] push_data,
    input  logic              pop,
    input  logic [IW-1:0]     pop_idx,
    output sb_entry_t         ent_o [DEPTH],
    output logic [CW-1:0]     count_o
);

    sb_entry_t     ent_q [DEPTH];
    sb_entry_t     ext   [DEPTH+1];
    sb_entry_t     nxt   [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;

    // Remove the drained slot by shifting younger entries down, then append.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) ext[i] = ent_q[i];
        ext[DEPTH] = '0;
        for (int i = 0; i < DEPTH; i++) begin
            nxt[i] = (pop && (i >= int'(pop_idx))) ? ext[i+1] : ext[i];
        end
        base = cnt_q - CW'(pop);
        if (push) begin
            nxt[base[IW-1:0]] = '{vld: 1'b1, addr: push_addr, data: push_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= nxt[i];
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign ent_o   = ent_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/sob_drain_sel.sv
module sob_drain_sel
    import sob_pkg::*;
#(
    parameter int DEPTH = SOB_DEPTH,
    localparam int IW = $clog2(DEPTH)
) (
    input  sb_entry_t            ent [DEPTH],
    input  logic                 pso,
    input  logic [SOB_BANKS-1:0] bank_rdy,
    output logic                 fire,
    output logic [IW-1:0]        idx
);

    logic [DEPTH-1:0] older_same;
    logic [DEPTH-1:0] cand;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            older_same[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (ent[j].vld && ent[j].addr == ent[i].addr) older_same[i] = 1'b1;
            end
            cand[i] = ent[i].vld && bank_rdy[bank_of(ent[i].addr)]
                    && !older_same[i] && (pso || i == 0);
        end
        fire = |cand;
        idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/sob_load_fwd.sv
module sob_load_fwd
    import sob_pkg::*;
#(
    parameter int DEPTH = SOB_DEPTH
) (
    input  sb_entry_t         ent [DEPTH],
    input  logic [SOB_AW-1:0] addr,
    output logic              hit,
    output logic [SOB_DW-1:0] data
);

    // Entries are kept oldest first, so the last match is the youngest.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent[i].vld && ent[i].addr == addr) begin
                hit  = 1'b1;
                data = ent[i].data;
            end
        end
    end

endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
    import sob_pkg::*;
#(
    parameter int DEPTH = SOB_DEPTH,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pso_mode,
    input  logic                 core_valid,
    input  logic [1:0]           core_op,
    input  logic [SOB_AW-1:0]    core_addr,
    input  logic [SOB_DW-1:0]    core_data,
    output logic                 core_ready,
    output logic                 ld_hit,
    output logic [SOB_DW-1:0]    ld_data,
    input  logic [SOB_BANKS-1:0] mem_bank_rdy,
    output logic                 mem_wr_valid,
    output logic [SOB_AW-1:0]    mem_wr_addr,
    output logic [SOB_DW-1:0]    mem_wr_data
);

    core_op_e      op;
    sb_entry_t     ent [DEPTH];
    logic [CW-1:0] occ;
    logic          st_push;
    logic          wr_fire;
    logic [IW-1:0] sel_idx;
    logic          fwd_hit;

    assign op = core_op_e'(core_op);

    always_comb begin
        unique case (op)
            OP_STORE: core_ready = (occ < CW'(DEPTH));
            OP_LOAD:  core_ready = 1'b1;
            default:  core_ready = (occ == '0);
        endcase
    end

    assign st_push = core_valid && core_ready && (op == OP_STORE);

    sob_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (st_push),
        .push_addr (core_addr),
        .push_data (core_data),
        .pop       (wr_fire),
        .pop_idx   (sel_idx),
        .ent_o     (ent),
        .count_o   (occ)
    );

    sob_drain_sel #(.DEPTH(DEPTH)) u_sel (
        .ent      (ent),
        .pso      (pso_mode),
        .bank_rdy (mem_bank_rdy),
        .fire     (wr_fire),
        .idx      (sel_idx)
    );

    sob_load_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ent  (ent),
        .addr (core_addr),
        .hit  (fwd_hit),
        .data (ld_data)
    );

    assign ld_hit       = core_valid && (op == OP_LOAD) && fwd_hit;
    assign mem_wr_valid = wr_fire;
    assign mem_wr_addr  = ent[sel_idx].addr;
    assign mem_wr_data  = ent[sel_idx].data;

endmodule

// File: rtl/sob_checker.sv
module sob_checker
    import sob_pkg::*;
#(
    parameter int DEPTH = SOB_DEPTH,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pso_mode,
    input logic                 core_valid,
    input logic [1:0]           core_op,
    input logic                 core_ready,
    input logic                 ld_hit,
    input logic [SOB_BANKS-1:0] mem_bank_rdy,
    input logic                 mem_wr_valid,
    input logic [SOB_AW-1:0]    mem_wr_addr,
    input sb_entry_t            ent [DEPTH],
    input logic [CW-1:0]        occ,
    input logic                 st_push,
    input logic                 wr_fire,
    input logic [IW-1:0]        sel_idx
);

    logic older_same;

    always_comb begin
        older_same = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(sel_idx) && ent[i].vld && ent[i].addr == mem_wr_addr) older_same = 1'b1;
        end
    end

    assert_empty_no_write_R1: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !mem_wr_valid);

    assert_store_stall_full_R2: assert property (@(posedge clk) disable iff (rst)
        (core_valid && core_op == 2'b00 && occ == CW'(DEPTH)) |-> !core_ready);

    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    assert_load_hit_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        ld_hit |-> (occ != '0));

    assert_fence_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (core_valid && core_op[1] && core_ready) |=> (occ == '0));

    assert_bank_ready_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> mem_bank_rdy[bank_of(mem_wr_addr)]);

    assert_tso_head_R8: assert property (@(posedge clk) disable iff (rst)
        (!pso_mode && mem_wr_valid) |-> (ent[0].vld && mem_wr_addr == ent[0].addr));

    assert_same_addr_order_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !older_same);

    assert_occ_grow_R11: assert property (@(posedge clk) disable iff (rst)
        (st_push && !wr_fire) |=> (occ == $past(occ) + CW'(1)));

endmodule

bind store_order_buffer sob_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pso_mode     (pso_mode),
    .core_valid   (core_valid),
    .core_op      (core_op),
    .core_ready   (core_ready),
    .ld_hit       (ld_hit),
    .mem_bank_rdy (mem_bank_rdy),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .ent          (ent),
    .occ          (occ),
    .st_push      (st_push),
    .wr_fire      (wr_fire),
    .sel_idx      (sel_idx)
);

// File: tb/store_order_buffer_tb.sv
module store_order_buffer_tb;
    import sob_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pso_mode = 1'b0;
    logic        core_valid = 1'b0;
    logic [1:0]  core_op = 2'b00;
    logic [15:0] core_addr = '0;
    logic [31:0] core_data = '0;
    logic        core_ready;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic [3:0]  mem_bank_rdy = '0;
    logic        mem_wr_valid;
    logic [15:0] mem_wr_addr;
    logic [31:0] mem_wr_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [15:0] m_addr [$];
    logic [31:0] m_data [$];

    always #2 clk = ~clk;

    store_order_buffer u_dut (
        .clk (clk), .rst (rst), .pso_mode (pso_mode),
        .core_valid (core_valid), .core_op (core_op), .core_addr (core_addr),
        .core_data (core_data), .core_ready (core_ready), .ld_hit (ld_hit),
        .ld_data (ld_data), .mem_bank_rdy (mem_bank_rdy), .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_drain(input logic pso, input logic [3:0] br);
        for (int i = 0; i < m_addr.size(); i++) begin
            bit blocked = 1'b0;
            for (int j = 0; j < i; j++) if (m_addr[j] == m_addr[i]) blocked = 1'b1;
            if ((pso || i == 0) && br[m_addr[i][1:0]] && !blocked) return i;
        end
        return -1;
    endfunction

    function automatic int exp_fwd(input logic [15:0] a);
        int k = -1;
        for (int i = 0; i < m_addr.size(); i++) if (m_addr[i] == a) k = i;
        return k;
    endfunction

    // Drive one cycle, check outputs before the edge, then update the model.
    task automatic step(input logic v, input logic [1:0] op, input logic [15:0] a,
                        input logic [31:0] d, input logic [3:0] br, input logic pso);
        bit exp_rdy;
        int di;
        int fi;
        @(negedge clk);
        core_valid = v; core_op = op; core_addr = a; core_data = d;
        mem_bank_rdy = br; pso_mode = pso;
        #1;
        case (op)
            2'b00:   exp_rdy = (m_addr.size() < 8);
            2'b01:   exp_rdy = 1'b1;
            default: exp_rdy = (m_addr.size() == 0);
        endcase
        if (v) begin
            if (op == 2'b00)      chk(core_ready == exp_rdy, "R2 store accept", 64'(core_ready), 64'(exp_rdy));
            else if (op == 2'b01) chk(core_ready == exp_rdy, "R3 load accept", 64'(core_ready), 64'(exp_rdy));
            else                  chk(core_ready == exp_rdy, "R6 barrier/atomic accept", 64'(core_ready), 64'(exp_rdy));
        end
        if (v && op == 2'b01) begin
            fi = exp_fwd(a);
            if (fi < 0) chk(ld_hit == 1'b0, "R5 load miss", 64'(ld_hit), 64'(0));
            else begin
                chk(ld_hit == 1'b1, "R4 load hit", 64'(ld_hit), 64'(1));
                chk(ld_data == m_data[fi], "R4 load data", 64'(ld_data), 64'(m_data[fi]));
            end
        end
        di = exp_drain(pso, br);
        chk(mem_wr_valid == (di >= 0), pso ? "R9 write valid" : "R8 write valid",
            64'(mem_wr_valid), 64'(di >= 0));
        if (di >= 0) begin
            chk(mem_wr_addr == m_addr[di], pso ? "R9 write addr" : "R8 write addr",
                64'(mem_wr_addr), 64'(m_addr[di]));
            chk(mem_wr_data == m_data[di], "R7 write data", 64'(mem_wr_data), 64'(m_data[di]));
            m_addr.delete(di);
            m_data.delete(di);
        end
        if (v && op == 2'b00 && exp_rdy) begin
            m_addr.push_back(a);
            m_data.push_back(d);
        end
    endtask

    initial begin
        void'($urandom(32'h0005_eed1));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        step(1'b1, 2'b10, 16'h0, 32'h0, 4'hF, 1'b0);
        chk(core_ready == 1'b1, "R1 barrier after reset", 64'(core_ready), 64'(1));
        chk(mem_wr_valid == 1'b0, "R1 no write after reset", 64'(mem_wr_valid), 64'(0));
        step(1'b1, 2'b01, 16'h0010, 32'h0, 4'hF, 1'b0);
        chk(ld_hit == 1'b0, "R1 load misses after reset", 64'(ld_hit), 64'(0));

        // R4/R11: youngest match forwards, next-cycle visibility
        step(1'b1, 2'b00, 16'h0010, 32'hA1, 4'h0, 1'b0);
        step(1'b1, 2'b01, 16'h0010, 32'h0, 4'h0, 1'b0);
        chk(ld_hit && ld_data == 32'hA1, "R11 forward next cycle", 64'(ld_data), 64'hA1);
        step(1'b1, 2'b00, 16'h0021, 32'hB1, 4'h0, 1'b0);
        step(1'b1, 2'b00, 16'h0010, 32'hA2, 4'h0, 1'b0);
        step(1'b1, 2'b01, 16'h0010, 32'h0, 4'h0, 1'b0);
        chk(ld_data == 32'hA2, "R4 youngest match", 64'(ld_data), 64'hA2);

        // R9/R10: pass a busy bank, keep same-address order
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'b0010, 1'b1);
        chk(mem_wr_valid && mem_wr_addr == 16'h0021, "R9 younger passes busy bank", 64'(mem_wr_addr), 64'h21);
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'b0001, 1'b1);
        chk(mem_wr_data == 32'hA1, "R10 same address first", 64'(mem_wr_data), 64'hA1);
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'b0001, 1'b1);
        chk(mem_wr_data == 32'hA2, "R10 same address second", 64'(mem_wr_data), 64'hA2);

        // R12: drained store no longer forwards
        step(1'b1, 2'b01, 16'h0010, 32'h0, 4'h0, 1'b1);
        chk(ld_hit == 1'b0, "R12 drained not forwarded", 64'(ld_hit), 64'(0));

        // R8: total order holds back younger store
        step(1'b1, 2'b00, 16'h0030, 32'hC1, 4'h0, 1'b0);
        step(1'b1, 2'b00, 16'h0031, 32'hC2, 4'h0, 1'b0);
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'b0010, 1'b0);
        chk(mem_wr_valid == 1'b0, "R8 head blocks younger", 64'(mem_wr_valid), 64'(0));
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'hF, 1'b0);
        step(1'b0, 2'b00, 16'h0, 32'h0, 4'hF, 1'b0);

        // R2/R3/R6: full buffer, store accept during drain (R11)
        for (int k = 0; k < 8; k++) step(1'b1, 2'b00, 16'(16'h0040 + k), 32'(k), 4'h0, 1'b1);
        step(1'b1, 2'b00, 16'h0050, 32'hEE, 4'hF, 1'b1);
        chk(core_ready == 1'b0, "R2 full refuses store", 64'(core_ready), 64'(0));
        step(1'b1, 2'b11, 16'h0, 32'h0, 4'h0, 1'b1);
        chk(core_ready == 1'b0, "R6 atomic stalls", 64'(core_ready), 64'(0));
        step(1'b1, 2'b01, 16'h0047, 32'h0, 4'h0, 1'b1);
        chk(core_ready == 1'b1, "R3 load while full", 64'(core_ready), 64'(1));
        step(1'b1, 2'b00, 16'h0051, 32'hEF, 4'hF, 1'b1);
        chk(core_ready == 1'b1 && mem_wr_valid, "R11 accept with drain", 64'(core_ready), 64'(1));
        for (int k = 0; k < 10; k++) step(1'b0, 2'b00, 16'h0, 32'h0, 4'hF, 1'b0);
        step(1'b1, 2'b10, 16'h0, 32'h0, 4'h0, 1'b0);
        chk(core_ready == 1'b1, "R6 barrier when empty", 64'(core_ready), 64'(1));

        // Random traffic, both modes
        for (int c = 0; c < 4000; c++) begin
            int r = int'($urandom_range(0, 99));
            logic [1:0] op = (r < 50) ? 2'b00 : (r < 80) ? 2'b01 : (r < 90) ? 2'b10 : 2'b11;
            step(($urandom_range(0, 9) != 0), op, 16'($urandom_range(0, 11)),
                 $urandom, 4'($urandom), ((c / 500) % 2) == 1);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule